// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Addressed Registers

This block collects up to 32 interrupt lines and raises a single request toward a processor. Each line has a sense chosen when the block is built: rising edge, falling edge, active-high level or active-low level. A qualifying event on a line sets that line's bit in a latched status word. The status bit stays set until software acknowledges it. A per-line enable word qualifies the status into a pending word. The request output is the OR of the pending bits, and it is gated by a two-bit master enable.

Software reaches the block through a small word-addressed register bus. Writes are single-cycle strobes, and reads are combinational from the register state. Enable bits can be changed atomically through set-only and clear-only write ports, so no read-modify-write is needed. A vector register returns the number of the lowest-numbered pending line, which lets an interrupt entry routine dispatch straight away.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While rst_ni is low, status, enable and master enable read 0, irq_o is 0, and the vector word (index 6) reads 0xFFFFFFFF.
- R2: Line n uses bit n of every register. Its sense is the 2-bit field SENSE[2n+1:2n]: 0 means rising edge, 1 falling edge, 2 high level, 3 low level. The default is n mod 4. A qualifying event sets status bit n (index 0) at the next clock edge.
- R3: Writing to index 4 ORs the data into the enable word (index 2). Enable bits whose data bit is 0 keep their value.
- R4: Writing to index 5 clears each enable bit whose data bit is 1. All other enable bits keep their value.
- R5: Writing to index 3 clears each status bit whose data bit is 1, and all ones clears every bit. A level line that is still active sets its status bit again.
- R6: irq_o is 1 only when both master-enable bits (index 7, bits 1:0) are 1 and at least one line is pending.
- R7: The pending word (index 1) reads status AND enable.
- R8: The vector word (index 6) reads the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R9: Indexes 3, 4 and 5 read 0. A write to index 2 replaces the whole enable word.
- R10: If a line has a qualifying event in the same cycle that the line is acknowledged, its status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Interrupt lines, synchronous to clk_i |
| wr_en_i | input | 1 | Write strobe for the register addressed by addr_i |
| addr_i | input | AW | Register word index |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Status, enable and master-enable changes caused by a line event or a write take effect at the next rising clock edge. Read data, pending, vector and irq_o follow that register state combinationally, with no further delay. The bench changes all inputs on the falling edge and checks reads and irq_o 1 ns after a falling edge. Any effect is therefore checked exactly one clock edge after the stimulus that caused it. Asynchronous reset is checked while rst_ni is still low, with no clock edge in between.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam logic [2:0] REG_STATUS  = 3'd0;
  localparam logic [2:0] REG_PENDING = 3'd1;
  localparam logic [2:0] REG_ENABLE  = 3'd2;
  localparam logic [2:0] REG_ACK     = 3'd3;
  localparam logic [2:0] REG_SET_EN  = 3'd4;
  localparam logic [2:0] REG_CLR_EN  = 3'd5;
  localparam logic [2:0] REG_VECTOR  = 3'd6;
  localparam logic [2:0] REG_MASTER  = 3'd7;

  // line n gets sense n mod 4
  function automatic logic [63:0] default_sense();
    logic [63:0] v;
    for (int n = 0; n < 32; n++) v[2*n +: 2] = 2'(n % 4);
    return v;
  endfunction
endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
  parameter logic [1:0] MODE = vic_pkg::SENSE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic event_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= line_i;
  end

  generate
    if (MODE == vic_pkg::SENSE_RISE) begin : g_rise
      assign event_o = line_i & ~prev_q;
    end else if (MODE == vic_pkg::SENSE_FALL) begin : g_fall
      assign event_o = ~line_i & prev_q;
    end else if (MODE == vic_pkg::SENSE_HIGH) begin : g_high
      assign event_o = line_i;
    end else begin : g_low
      assign event_o = ~line_i;
    end
  endgenerate
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int                   N_IRQ = 32,
  parameter int                   DW    = 32,
  parameter int                   AW    = 3,
  parameter logic [2*N_IRQ-1:0]   SENSE = (2*N_IRQ)'(vic_pkg::default_sense())
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             irq_o
);
  import vic_pkg::*;

  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [N_IRQ-1:0] status_q, en_q, ev, pending, wmask, ack_mask, en_d;
  logic [1:0]       mer_q;
  logic             vec_valid;
  logic [IW-1:0]    vec_idx;
  logic [2:0]       reg_sel;

  assign reg_sel = 3'(addr_i);
  assign wmask   = wr_data_i[N_IRQ-1:0];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    vic_sense #(.MODE(SENSE[2*g +: 2])) u_sense (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (irq_i[g]),
      .event_o(ev[g])
    );
  end

  assign ack_mask = (wr_en_i && reg_sel == REG_ACK) ? wmask : '0;

  always_comb begin
    en_d = en_q;
    if (wr_en_i) begin
      unique case (reg_sel)
        REG_ENABLE: en_d = wmask;
        REG_SET_EN: en_d = en_q | wmask;
        REG_CLR_EN: en_d = en_q & ~wmask;
        default:    en_d = en_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
      mer_q    <= '0;
    end else begin
      status_q <= (status_q & ~ack_mask) | ev;  // new event beats ack
      en_q     <= en_d;
      if (wr_en_i && reg_sel == REG_MASTER) mer_q <= wr_data_i[1:0];
    end
  end

  assign pending = status_q & en_q;

  vic_prio #(.N(N_IRQ), .IW(IW)) u_prio (
    .req_i  (pending),
    .valid_o(vec_valid),
    .idx_o  (vec_idx)
  );

  assign irq_o = (&mer_q) & vec_valid;

  always_comb begin
    unique case (reg_sel)
      REG_STATUS:  rd_data_o = DW'(status_q);
      REG_PENDING: rd_data_o = DW'(pending);
      REG_ENABLE:  rd_data_o = DW'(en_q);
      REG_VECTOR:  rd_data_o = vec_valid ? DW'(vec_idx) : {DW{1'b1}};
      REG_MASTER:  rd_data_o = DW'(mer_q);
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N_IRQ = 32,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             irq_o,
  input logic [N_IRQ-1:0] status_q,
  input logic [N_IRQ-1:0] en_q,
  input logic [N_IRQ-1:0] ev,
  input logic [1:0]       mer_q
);
  import vic_pkg::*;

  logic [N_IRQ-1:0] wbits;
  assign wbits = wr_data_i[N_IRQ-1:0];

  p_master_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mer_q != 2'b11) |-> !irq_o);

  p_irq_needs_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(status_q & en_q)));

  p_set_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 3'(addr_i) == REG_SET_EN) |=> ((en_q & $past(wbits)) == $past(wbits)));

  p_clr_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 3'(addr_i) == REG_CLR_EN) |=> ((en_q & $past(wbits)) == '0));

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 3'(addr_i) == REG_ACK) |=> ((status_q & $past(wbits & ~ev)) == '0));

  p_event_latched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((status_q & $past(ev)) == $past(ev)));

  p_vector_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (3'(addr_i) == REG_VECTOR && (status_q & en_q) == '0) |-> (rd_data_o == {DW{1'b1}}));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .status_q (status_q),
  .en_q     (en_q),
  .ev       (ev),
  .mer_q    (mer_q)
);

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  localparam logic [31:0] I = 32'hAAAA_AAAA;  // idle: falling and low lines held high
  localparam logic [1:0] OP_NOP = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] irq;
    logic [31:0] exp;
    logic [3:0]  req;
  } row_t;

  localparam int NROW = 66;
  localparam row_t TBL [NROW] = '{
    '{OP_RD , 3'd0, 32'h0, I, 32'h0, 4'd1},                // R1 after reset
    '{OP_RD , 3'd2, 32'h0, I, 32'h0, 4'd1},
    '{OP_RD , 3'd6, 32'h0, I, 32'hFFFF_FFFF, 4'd1},
    '{OP_RD , 3'd7, 32'h0, I, 32'h0, 4'd1},
    '{OP_NOP, 3'd0, 32'h0, I | 32'h1, 32'h0, 4'd0},        // R2 line0 rises
    '{OP_RD , 3'd0, 32'h0, I | 32'h1, 32'h1, 4'd2},
    '{OP_NOP, 3'd0, 32'h0, I, 32'h0, 4'd0},
    '{OP_NOP, 3'd0, 32'h0, I ^ 32'h2, 32'h0, 4'd0},        // R2 line1 falls
    '{OP_RD , 3'd0, 32'h0, I ^ 32'h2, 32'h3, 4'd2},
    '{OP_NOP, 3'd0, 32'h0, I, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I, 32'h3, 4'd2},                // R2 rise on falling line: no event
    '{OP_WR , 3'd4, 32'h6, I, 32'h0, 4'd0},
    '{OP_RD , 3'd2, 32'h0, I, 32'h6, 4'd3},                // R3
    '{OP_RD , 3'd1, 32'h0, I, 32'h2, 4'd7},                // R7
    '{OP_RD , 3'd6, 32'h0, I, 32'h1, 4'd8},                // R8
    '{OP_IRQ, 3'd0, 32'h0, I, 32'h0, 4'd6},                // R6 master off
    '{OP_WR , 3'd7, 32'h1, I, 32'h0, 4'd0},
    '{OP_IRQ, 3'd0, 32'h0, I, 32'h0, 4'd6},                // R6 one bit only
    '{OP_WR , 3'd7, 32'h3, I, 32'h0, 4'd0},
    '{OP_IRQ, 3'd0, 32'h0, I, 32'h1, 4'd6},
    '{OP_WR , 3'd4, 32'h1, I, 32'h0, 4'd0},
    '{OP_RD , 3'd6, 32'h0, I, 32'h0, 4'd8},                // R8 lowest wins
    '{OP_WR , 3'd5, 32'h5, I, 32'h0, 4'd0},
    '{OP_RD , 3'd2, 32'h0, I, 32'h2, 4'd4},                // R4
    '{OP_RD , 3'd4, 32'h0, I, 32'h0, 4'd9},                // R9
    '{OP_RD , 3'd5, 32'h0, I, 32'h0, 4'd9},
    '{OP_RD , 3'd3, 32'h0, I, 32'h0, 4'd9},
    '{OP_WR , 3'd3, 32'h2, I, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I, 32'h1, 4'd5},                // R5
    '{OP_IRQ, 3'd0, 32'h0, I, 32'h0, 4'd6},
    '{OP_RD , 3'd6, 32'h0, I, 32'hFFFF_FFFF, 4'd8},
    '{OP_NOP, 3'd0, 32'h0, I | 32'h4, 32'h0, 4'd0},        // line2 high level
    '{OP_RD , 3'd0, 32'h0, I | 32'h4, 32'h5, 4'd2},
    '{OP_WR , 3'd3, 32'h4, I | 32'h4, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I | 32'h4, 32'h5, 4'd5},        // R5 level re-sets
    '{OP_NOP, 3'd0, 32'h0, I, 32'h0, 4'd0},
    '{OP_WR , 3'd3, 32'hFFFF_FFFF, I, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I, 32'h0, 4'd5},                // R5 ack all
    '{OP_NOP, 3'd0, 32'h0, I & ~32'h8, 32'h0, 4'd0},       // line3 low level
    '{OP_RD , 3'd0, 32'h0, I & ~32'h8, 32'h8, 4'd2},
    '{OP_NOP, 3'd0, 32'h0, I, 32'h0, 4'd0},
    '{OP_WR , 3'd3, 32'hFFFF_FFFF, I, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I, 32'h0, 4'd5},
    '{OP_WR , 3'd2, 32'h10, I, 32'h0, 4'd0},
    '{OP_RD , 3'd2, 32'h0, I, 32'h10, 4'd9},               // R9 direct write
    '{OP_NOP, 3'd0, 32'h0, I | 32'h10, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I | 32'h10, 32'h10, 4'd2},
    '{OP_WR , 3'd3, 32'h10, I, 32'h0, 4'd0},
    '{OP_RD , 3'd0, 32'h0, I, 32'h0, 4'd5},
    '{OP_WR , 3'd3, 32'h10, I | 32'h10, 32'h0, 4'd0},      // R10 edge with ack
    '{OP_RD , 3'd0, 32'h0, I | 32'h10, 32'h10, 4'd10},
    '{OP_IRQ, 3'd0, 32'h0, I | 32'h10, 32'h1, 4'd6},
    '{OP_WR , 3'd7, 32'h0, I | 32'h10, 32'h0, 4'd0},
    '{OP_IRQ, 3'd0, 32'h0, I | 32'h10, 32'h0, 4'd6},
    '{OP_RD , 3'd1, 32'h0, I | 32'h10, 32'h10, 4'd7},
    '{OP_WR , 3'd4, 32'hFFFF_FFFF, I, 32'h0, 4'd0},
    '{OP_RD , 3'd6, 32'h0, I, 32'h4, 4'd8},
    '{OP_NOP, 3'd0, 32'h0, 32'h2AAA_AAEA, 32'h0, 4'd0},    // line31 low, line6 high
    '{OP_WR , 3'd3, 32'h10, 32'h2AAA_AAEA, 32'h0, 4'd0},
    '{OP_RD , 3'd6, 32'h0, 32'h2AAA_AAEA, 32'h6, 4'd8},
    '{OP_RD , 3'd1, 32'h0, 32'h2AAA_AAEA, 32'h8000_0040, 4'd7},
    '{OP_NOP, 3'd0, 32'h0, I, 32'h0, 4'd0},
    '{OP_WR , 3'd3, 32'h40, I, 32'h0, 4'd0},
    '{OP_RD , 3'd6, 32'h0, I, 32'd31, 4'd8},
    '{OP_WR , 3'd3, 32'hFFFF_FFFF, I, 32'h0, 4'd0},
    '{OP_RD , 3'd6, 32'h0, I, 32'hFFFF_FFFF, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = I;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [31:0] exp, input int req);
    addr_i = a;
    #1 check(rd_data_o, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 while reset is held
    wr_en_i = 1'b0;
    read_chk(3'd0, 32'h0, 1);
    read_chk(3'd6, 32'hFFFF_FFFF, 1);
    check({31'b0, irq_o}, 32'h0, 1);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int k = 0; k < NROW; k++) begin
      @(negedge clk);
      irq_i     = TBL[k].irq;
      addr_i    = TBL[k].addr;
      wr_data_i = TBL[k].data;
      wr_en_i   = (TBL[k].op == OP_WR);
      if (TBL[k].op == OP_RD)
        #1 check(rd_data_o, TBL[k].exp, int'(TBL[k].req));
      else if (TBL[k].op == OP_IRQ)
        #1 check({31'b0, irq_o}, TBL[k].exp, int'(TBL[k].req));
    end

    // R1 directed: asynchronous reset clears live state
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'd7; wr_data_i = 32'h3;
    @(negedge clk);
    wr_en_i = 1'b0; irq_i = I | 32'h40;
    @(negedge clk);
    check({31'b0, irq_o}, 32'h1, 6);
    rst_ni = 1'b0;
    read_chk(3'd0, 32'h0, 1);
    read_chk(3'd2, 32'h0, 1);
    read_chk(3'd7, 32'h0, 1);
    check({31'b0, irq_o}, 32'h0, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #4_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule